// File: doc/BRIEF.md
# GPIO Change-Detect Register Bank

This block is one 32-bit memory-mapped word that serves a group of five general-purpose pins. Each pin owns a three-bit group in the word. The group holds a read-only view of the synchronized pin level, a read-write drive value and a sticky status flag. The status flag records any level transition on the pin, whether rising or falling. Software clears a flag by writing 1 to it. Each flag, gated by a per-pin enable, raises a per-pin interrupt request.

The register port is synchronous. A write takes effect on the clock edge where `wrEn` is high. `rdData` always shows the current content of the word. Pin direction and interrupt enables come in as plain inputs from elsewhere in the chip. Pad logic and interrupt aggregation sit outside the block.

Top module: `gpio_cdr_bank`

## Requirements
- R1: After reset every field is 0: `rdData` reads 0, `irq` is 0 and `pinOut` is 0.
- R2: Pin index k (0..4) owns bits 16+3k to 18+3k: bit 16+3k is its status flag, bit 17+3k is its drive value and bit 18+3k is its input level.
- R3: Bit 31 and bits 15 down to 0 always read 0, and writing to them has no effect.
- R4: The input bit shows the pin level through a two-stage synchronizer. A pin change made before clock edge 1 is still unseen after edge 1 and is visible after edge 2. Writing the input bit has no effect.
- R5: The drive bit is loaded from the written data on every write. `pinOut[k]` equals the drive bit when `dirOut[k]` is 1 and is 0 otherwise. `pinOe` follows `dirOut`.
- R6: A status flag sets on both rising and falling pin transitions. For a pin change made before edge 1, the flag reads 0 after edge 2 and reads 1 after edge 3.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A cleared flag stays 0 while the pin is stable.
- R8: If a transition sets a status flag in the same cycle that a write-1 clears it, the flag ends up set.
- R9: `irq[k]` is 1 exactly when the status flag of pin k is 1 and `irqEn[k]` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Current register content |
| pinIn | input | 5 | Asynchronous pin levels |
| dirOut | input | 5 | Per-pin direction, 1 means the pin is an output |
| irqEn | input | 5 | Per-pin interrupt enable |
| pinOut | output | 5 | Pin drive values |
| pinOe | output | 5 | Pin output enables |
| irq | output | 5 | Per-pin interrupt requests |

## Verification
Several pin patterns are applied: some pins rising together, then a subset falling. This separates detection on both edges from rising-only detection and keeps each pin's flag apart from its neighbours. The reads after edges 1, 2 and 3 pin down the synchronizer depth and the status latency. Write-data patterns that mix 1s and 0s in the status bits separate clearing a single flag from clearing all of them and from a write of 0 that must not clear. A clear timed onto the very edge where a flag sets is what tells set-priority apart from clear-priority.

// File: rtl/gpio_cdr_pkg.sv
package gpio_cdr_pkg;

  // Geometry of the register word
  localparam int PIN_CNT    = 5;
  localparam int REG_W      = 32;
  localparam int FIELD_BASE = 16;
  localparam int GROUP_W    = 3;
  localparam int SYNC_DEPTH = 2;

  // Position of each bit inside a pin group
  localparam int STAT_OFS = 0;
  localparam int OUT_OFS  = 1;
  localparam int IN_OFS   = 2;

  // Strobes from the write decoder to the datapath
  typedef struct packed {
    logic               outLoad;
    logic [PIN_CNT-1:0] outVal;
    logic [PIN_CNT-1:0] statClr;
  } ctrl_strobe_t;

  function automatic int statPos(input int k);
    return FIELD_BASE + GROUP_W * k + STAT_OFS;
  endfunction

  function automatic int outPos(input int k);
    return FIELD_BASE + GROUP_W * k + OUT_OFS;
  endfunction

  function automatic int inPos(input int k);
    return FIELD_BASE + GROUP_W * k + IN_OFS;
  endfunction

endpackage

// File: rtl/gpio_cdr_ctrl.sv
module gpio_cdr_ctrl
  import gpio_cdr_pkg::*;
(
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output ctrl_strobe_t     strobe
);

  // Input and reserved bits are not decoded.
  logic unusedWrBits;
  assign unusedWrBits = ^wrData;

  always_comb begin
    strobe.outLoad = wrEn;
    for (int k = 0; k < PIN_CNT; k++) begin
      strobe.outVal[k]  = wrData[outPos(k)];
      strobe.statClr[k] = wrEn & wrData[statPos(k)];
    end
  end

endmodule

// File: rtl/gpio_cdr_datapath.sv
module gpio_cdr_datapath
  import gpio_cdr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobe,
  input  logic [PIN_CNT-1:0] pinIn,
  input  logic [PIN_CNT-1:0] dirOut,
  input  logic [PIN_CNT-1:0] irqEn,
  output logic [REG_W-1:0]   rdData,
  output logic [PIN_CNT-1:0] pinOut,
  output logic [PIN_CNT-1:0] pinOe,
  output logic [PIN_CNT-1:0] irq
);

  logic [PIN_CNT-1:0] syncLvl;
  logic [PIN_CNT-1:0] prevLvl;
  logic [PIN_CNT-1:0] edgeHit;
  logic [PIN_CNT-1:0] statQ;
  logic [PIN_CNT-1:0] outQ;

  // One synchronizer chain per pin
  for (genvar p = 0; p < PIN_CNT; p++) begin : g_sync
    logic [SYNC_DEPTH-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_DEPTH-2:0], pinIn[p]};
    end
    assign syncLvl[p] = chain[SYNC_DEPTH-1];
  end

  assign edgeHit = syncLvl ^ prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl <= '0;
      statQ   <= '0;
      outQ    <= '0;
    end else begin
      prevLvl <= syncLvl;
      // A new transition takes priority over a software clear
      statQ   <= edgeHit | (statQ & ~strobe.statClr);
      if (strobe.outLoad) outQ <= strobe.outVal;
    end
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < PIN_CNT; k++) begin
      rdData[statPos(k)] = statQ[k];
      rdData[outPos(k)]  = outQ[k];
      rdData[inPos(k)]   = syncLvl[k];
    end
  end

  assign pinOut = outQ & dirOut;
  assign pinOe  = dirOut;
  assign irq    = statQ & irqEn;

endmodule

// File: rtl/gpio_cdr_bank.sv
module gpio_cdr_bank
  import gpio_cdr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic [PIN_CNT-1:0] pinIn,
  input  logic [PIN_CNT-1:0] dirOut,
  input  logic [PIN_CNT-1:0] irqEn,
  output logic [PIN_CNT-1:0] pinOut,
  output logic [PIN_CNT-1:0] pinOe,
  output logic [PIN_CNT-1:0] irq
);

  ctrl_strobe_t strobe;

  gpio_cdr_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrData (wrData),
    .strobe (strobe)
  );

  gpio_cdr_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .pinIn  (pinIn),
    .dirOut (dirOut),
    .irqEn  (irqEn),
    .rdData (rdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irq    (irq)
  );

endmodule

// File: rtl/gpio_cdr_checker.sv
module gpio_cdr_checker
  import gpio_cdr_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [REG_W-1:0]   wrData,
  input logic [REG_W-1:0]   rdData,
  input logic [PIN_CNT-1:0] dirOut,
  input logic [PIN_CNT-1:0] irqEn,
  input logic [PIN_CNT-1:0] pinOut,
  input logic [PIN_CNT-1:0] pinOe,
  input logic [PIN_CNT-1:0] irq
);

  logic unusedChk;
  assign unusedChk = ^wrData;

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[REG_W-1] == 1'b0) && (rdData[FIELD_BASE-1:0] == '0));

  a_r5_oe_follows: assert property (@(posedge clk) disable iff (!rstN)
    pinOe == dirOut);

  for (genvar k = 0; k < PIN_CNT; k++) begin : g_pin
    localparam int SB = FIELD_BASE + GROUP_W * k + STAT_OFS;
    localparam int OB = FIELD_BASE + GROUP_W * k + OUT_OFS;
    localparam int IB = FIELD_BASE + GROUP_W * k + IN_OFS;

    a_r5_pin_drive: assert property (@(posedge clk) disable iff (!rstN)
      pinOut[k] == (dirOut[k] & rdData[OB]));

    a_r5_out_hold: assert property (@(posedge clk) disable iff (!rstN)
      !wrEn |=> $stable(rdData[OB]));

    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
      irq[k] == (rdData[SB] & irqEn[k]));

    a_r6_set_cause: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rdData[SB]) |-> ($past(rdData[IB]) != $past(rdData[IB], 2)));

    a_r7_clear_cause: assert property (@(posedge clk) disable iff (!rstN)
      $fell(rdData[SB]) |-> $past(wrEn && wrData[SB]));

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rdData[IB]) != $past(rdData[IB], 2)) |-> rdData[SB]);
  end

endmodule

bind gpio_cdr_bank gpio_cdr_checker u_chk (.*);

// File: tb/tb_gpio_cdr_bank.sv
module tb_gpio_cdr_bank;
  import gpio_cdr_pkg::*;

  logic               clk = 1'b0;
  logic               rstN;
  logic               wrEn;
  logic [REG_W-1:0]   wrData;
  logic [REG_W-1:0]   rdData;
  logic [PIN_CNT-1:0] pinIn;
  logic [PIN_CNT-1:0] dirOut;
  logic [PIN_CNT-1:0] irqEn;
  logic [PIN_CNT-1:0] pinOut;
  logic [PIN_CNT-1:0] pinOe;
  logic [PIN_CNT-1:0] irq;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  gpio_cdr_bank dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Field packing written from R2
  function automatic logic [31:0] packF(input logic [4:0] v, input int ofs);
    logic [31:0] r = '0;
    for (int k = 0; k < 5; k++) r[16 + 3 * k + ofs] = v[k];
    return r;
  endfunction

  function automatic logic [4:0] getF(input logic [31:0] d, input int ofs);
    logic [4:0] r;
    for (int k = 0; k < 5; k++) r[k] = d[16 + 3 * k + ofs];
    return r;
  endfunction

  task automatic ticks(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wrReg(input logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic t_reset();
    chk("R1 rdData", rdData, 32'h0);
    chk("R1 irq", {27'h0, irq}, 32'h0);
    chk("R1 pinOut", {27'h0, pinOut}, 32'h0);
  endtask

  task automatic t_output();
    logic [4:0] pats [4] = '{5'b10101, 5'b01010, 5'b11111, 5'b00000};
    dirOut = 5'b11111;
    foreach (pats[i]) begin
      wrReg(packF(pats[i], 1));
      chk("R2 layout", rdData, packF(pats[i], 1));
      chk("R5 pinOut", {27'h0, pinOut}, {27'h0, pats[i]});
    end
    wrReg(packF(5'b11111, 1));
    dirOut = 5'b00110;
    #1;
    chk("R5 pinOut dir", {27'h0, pinOut}, 32'h6);
    chk("R5 pinOe", {27'h0, pinOe}, 32'h6);
    wrReg('0);
  endtask

  task automatic t_reserved();
    wrReg(32'hFFFF_FFFF);
    chk("R3 reserved/R4 input write", rdData, packF(5'b11111, 1));
    wrReg('0);
    chk("R3 cleanup", rdData, 32'h0);
  endtask

  task automatic t_input_edges();
    pinIn = 5'b01101;
    ticks(1);
    chk("R4 after edge1", {27'h0, getF(rdData, 2)}, 32'h0);
    ticks(1);
    chk("R4 after edge2", {27'h0, getF(rdData, 2)}, 32'hD);
    chk("R6 stat after edge2", {27'h0, getF(rdData, 0)}, 32'h0);
    ticks(1);
    chk("R6 rising", {27'h0, getF(rdData, 0)}, 32'hD);
    wrReg(packF(5'b11111, 0));
    chk("R7 clear all", {27'h0, getF(rdData, 0)}, 32'h0);
    pinIn = 5'b00100;
    ticks(3);
    chk("R6 falling", {27'h0, getF(rdData, 0)}, 32'h9);
    chk("R4 level", {27'h0, getF(rdData, 2)}, 32'h4);
  endtask

  task automatic t_clear();
    wrReg(packF(5'b00001, 0));
    chk("R7 single clear", {27'h0, getF(rdData, 0)}, 32'h8);
    ticks(5);
    chk("R7 stays clear", {27'h0, getF(rdData, 0)}, 32'h8);
    wrReg('0);
    chk("R7 write0 keeps", {27'h0, getF(rdData, 0)}, 32'h8);
    wrReg(packF(5'b11111, 0));
    chk("R7 clear rest", {27'h0, getF(rdData, 0)}, 32'h0);
  endtask

  task automatic t_collision();
    pinIn = 5'b00000;
    ticks(2);
    wrEn = 1'b1; wrData = packF(5'b00100, 0);
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    chk("R8 set wins", {27'h0, getF(rdData, 0)}, 32'h4);
    wrReg(packF(5'b00100, 0));
    chk("R8 later clear", {27'h0, getF(rdData, 0)}, 32'h0);
  endtask

  task automatic t_irq();
    irqEn = 5'b00000;
    pinIn = 5'b10011;
    ticks(3);
    chk("R9 stat", {27'h0, getF(rdData, 0)}, 32'h13);
    chk("R9 disabled", {27'h0, irq}, 32'h0);
    irqEn = 5'b11010; #1;
    chk("R9 partial", {27'h0, irq}, 32'h12);
    irqEn = 5'b11111; #1;
    chk("R9 full", {27'h0, irq}, 32'h13);
    wrReg(packF(5'b10000, 0));
    chk("R9 after clear", {27'h0, irq}, 32'h03);
    wrReg(packF(5'b11111, 0));
    chk("R9 all clear", {27'h0, irq}, 32'h0);
  endtask

  initial begin
    #(20 * 100000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrData = '0;
    pinIn = '0; dirOut = '0; irqEn = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    rstN = 1'b1;
    ticks(1);
    t_reset();
    t_output();
    t_reserved();
    t_input_edges();
    t_clear();
    t_collision();
    t_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule